// File: doc/BRIEF.md
# Uncorrectable Error Register Bank

This block holds the three configuration-space registers that record uncorrectable link and transaction errors: a sticky status register, a mask register and a severity register, placed at consecutive dword offsets. Link, transaction and completion logic report errors as single-cycle pulses on a 32-bit event vector. Each event bit sits at the same position as the status bit it sets.

Software reads the registers and clears status bits through a simple register port. The port has a byte address, write data, a write strobe, a read strobe and registered read data.

From the three registers the block forms two level outputs. One flags unmasked errors classed as fatal. The other flags unmasked errors classed as non-fatal. These two levels feed the error-message logic elsewhere in the chip.

Top module: `uerr_regbank`

## Requirements
- R1: The status register is at byte address 0x104, the mask register at 0x108 and the severity register at 0x10C. A read of any other address returns zero, and a write to any other address changes nothing.
- R2: After reset, status reads 0x0000_0000, mask reads 0x0000_0000 and severity reads 0x0006_0031.
- R3: A one on `err_evt` at bit 4, 5, 12, 14, 15, 16, 18, 19 or 20 sets the status bit at that position, whatever the mask holds. The bit stays set until software clears it.
- R4: A status write clears exactly those bits among 4, 5, 12, 14, 15, 16, 18, 19 and 20 whose write data is one. Write data of zero leaves those bits unchanged.
- R5: When an event and a clearing status write hit the same bit in the same cycle, the bit ends up set.
- R6: Bits 31:21, 11:6, 3:1 and bit 13 read as zero in all three registers, and writes to them have no effect.
- R7: Status bit 17 always reads zero, and an event on bit 17 is ignored. Mask bit 17 and severity bit 17 can be read and written.
- R8: Status bit 0 takes the value of write data bit 0 on every status write. An event on bit 0 is ignored.
- R9: Mask and severity store written data on the implemented positions 0x001F_D031.
- R10: `fatal_o` is high when, for any bit among 4, 5, 12, 14, 15, 16, 18, 19 and 20, status is 1, mask is 0 and severity is 1. `nonfatal_o` is high under the same conditions with severity 0. Both outputs follow the registers combinationally.
- R11: `reg_rdata` loads on the clock edge that samples `reg_rd` high. It shows the register contents from before any write in that same cycle, and holds its value while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt | input | 32 | Error event pulses, one bit per status position |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| fatal_o | output | 1 | Unmasked fatal error pending |
| nonfatal_o | output | 1 | Unmasked non-fatal error pending |

## Verification
The hardest situation to create from the ports is an event pulse that arrives on the same edge as a software clear of the same bit. The bench reaches it by driving `err_evt` and a status write in one cycle for every clearable bit, then reading the status register back.

The bench also walks a single event across all 32 positions, and checks that both outputs respond as R10 requires. For each clearable bit it tries all four mask and severity combinations and compares the outputs against values worked out arithmetically.

// File: rtl/uerr_pkg.sv
`timescale 1ns/1ps
// Package: bit-position constants shared by the uncorrectable error bank.
// Assumes 32-bit registers; bit 13 is left out of every implemented set.
package uerr_pkg;
    localparam int          REG_W      = 32;
    // error status bits cleared by writing one
    localparam logic [31:0] ERR_W1C    = 32'h001D_D030;
    // status bit that behaves as plain read/write
    localparam logic [31:0] STS_RW     = 32'h0000_0001;
    // implemented mask / severity positions
    localparam logic [31:0] CTRL_IMPL  = 32'h001F_D031;
    // severity reset pattern before hardwired-zero bits are removed
    localparam logic [31:0] SEV_RST_RAW = 32'h0006_2031;
    localparam logic [31:0] SEV_RST    = SEV_RST_RAW & CTRL_IMPL;
    localparam logic [31:0] MSK_RST    = 32'h0000_0000;
endpackage

// File: rtl/uerr_status_reg.sv
`timescale 1ns/1ps
// Module: sticky error status register.
// Events set W1C_BITS; a write clears W1C_BITS where data is one and loads
// RW_BITS directly. Events win over a same-cycle clear. Other bits stay zero.
module uerr_status_reg #(
    parameter int          W        = 32,
    parameter logic [W-1:0] W1C_BITS = '0,
    parameter logic [W-1:0] RW_BITS  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] IMPL = W1C_BITS | RW_BITS;

    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;
    logic [W-1:0] nxt;

    // next-state: keep, clear written ones, reload RW bits, then apply events
    always_comb begin
        set_v = evt & W1C_BITS;
        clr_v = wr_en ? (wdata & W1C_BITS) : '0;
        nxt   = q & ~clr_v;
        if (wr_en) begin
            nxt = (nxt & ~RW_BITS) | (wdata & RW_BITS);
        end
        nxt = (nxt | set_v) & IMPL;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/uerr_ctrl_reg.sv
`timescale 1ns/1ps
// Module: plain read/write control register (mask or severity).
// Only IMPL positions store data; reset value is RST limited to IMPL.
module uerr_ctrl_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] IMPL = '0,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RST_EFF = RST & IMPL;

    // load implemented bits on write
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RST_EFF;
        else if (wr_en) q <= wdata & IMPL;
    end
endmodule

// File: rtl/uerr_sev_decode.sv
`timescale 1ns/1ps
// Module: split pending unmasked errors by severity class.
// Purely combinational; considers only ERR_BITS positions.
module uerr_sev_decode #(
    parameter int          W        = 32,
    parameter logic [W-1:0] ERR_BITS = '0
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] sev,
    output logic         fatal,
    output logic         nonfatal
);
    logic [W-1:0] live;

    // unmasked pending errors, then OR-reduce per class
    always_comb begin
        live     = status & ~mask & ERR_BITS;
        fatal    = |(live & sev);
        nonfatal = |(live & ~sev);
    end
endmodule

// File: rtl/uerr_regbank.sv
`timescale 1ns/1ps
// Module: uncorrectable error register bank (status, mask, severity).
// Assumes a single-beat register port with byte addresses; reads are
// registered and return contents sampled before a same-cycle write.
module uerr_regbank #(
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] STS_OFF = 12'h104,
    parameter logic [11:0] MSK_OFF = 12'h108,
    parameter logic [11:0] SEV_OFF = 12'h10C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       err_evt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    output logic              fatal_o,
    output logic              nonfatal_o
);
    import uerr_pkg::*;

    logic hit_sts, hit_msk, hit_sev;
    logic [REG_W-1:0] status_q, mask_q, sev_q, rd_mux;

    // address decode
    always_comb begin
        hit_sts = (reg_addr == ADDR_W'(STS_OFF));
        hit_msk = (reg_addr == ADDR_W'(MSK_OFF));
        hit_sev = (reg_addr == ADDR_W'(SEV_OFF));
    end

    uerr_status_reg #(.W(REG_W), .W1C_BITS(ERR_W1C), .RW_BITS(STS_RW)) u_sts (
        .clk(clk), .rst_n(rst_n), .evt(err_evt),
        .wr_en(reg_wr && hit_sts), .wdata(reg_wdata), .q(status_q));

    uerr_ctrl_reg #(.W(REG_W), .IMPL(CTRL_IMPL), .RST(MSK_RST)) u_msk (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_msk),
        .wdata(reg_wdata), .q(mask_q));

    uerr_ctrl_reg #(.W(REG_W), .IMPL(CTRL_IMPL), .RST(SEV_RST_RAW)) u_sev (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_sev),
        .wdata(reg_wdata), .q(sev_q));

    uerr_sev_decode #(.W(REG_W), .ERR_BITS(ERR_W1C)) u_dec (
        .status(status_q), .mask(mask_q), .sev(sev_q),
        .fatal(fatal_o), .nonfatal(nonfatal_o));

    // read multiplexer; unmapped addresses give zero
    always_comb begin
        rd_mux = '0;
        if (hit_sts)      rd_mux = status_q;
        else if (hit_msk) rd_mux = mask_q;
        else if (hit_sev) rd_mux = sev_q;
    end

    // read data register
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/uerr_regbank_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound into uerr_regbank.
// Assumes the default register offsets of the top module.
module uerr_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] err_evt,
    input logic [11:0] reg_addr,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [31:0] reg_rdata,
    input logic        fatal_o,
    input logic        nonfatal_o,
    input logic [31:0] status_q,
    input logic [31:0] mask_q,
    input logic [31:0] sev_q
);
    import uerr_pkg::*;

    logic unmapped;
    // address outside the three registers
    always_comb unmapped = !(reg_addr == 12'h104 || reg_addr == 12'h108 || reg_addr == 12'h10C);

    AST_UNMAPPED_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && unmapped) |=> ($stable(mask_q) && $stable(sev_q))); // R1
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_evt & ERR_W1C)) |=> ((($past(err_evt) & ERR_W1C) & ~status_q) == 32'h0)); // R3
    AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !(|(err_evt & ERR_W1C))) |=> $stable(status_q)); // R4
    AST_RDATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rdata & ~CTRL_IMPL) == 32'h0)); // R6
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & ERR_W1C) == ERR_W1C) |-> (!fatal_o && !nonfatal_o)); // R10
    AST_OUT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal_o || nonfatal_o) |-> (|(status_q & ERR_W1C))); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R11
endmodule

bind uerr_regbank uerr_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .fatal_o(fatal_o), .nonfatal_o(nonfatal_o),
    .status_q(status_q), .mask_q(mask_q), .sev_q(sev_q));

// File: tb/uerr_regbank_test.sv
`timescale 1ns/1ps
// Bench: sweeps every bit position and every mask/severity pairing.
module uerr_regbank_test;
    localparam logic [11:0] A_STS = 12'h104, A_MSK = 12'h108, A_SEV = 12'h10C;
    localparam logic [31:0] CLR_BITS = 32'h001D_D030;
    localparam logic [31:0] CTRL_BITS = 32'h001F_D031;
    localparam logic [31:0] SEV_INIT = 32'h0006_0031;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] err_evt = '0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic fatal_o, nonfatal_o;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uerr_regbank uut (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .fatal_o(fatal_o), .nonfatal_o(nonfatal_o));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk); err_evt = v;
        @(negedge clk); err_evt = '0;
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-reqs act=running exp=finished");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset values, R1 unmapped read
        rd(A_STS, d); chk("R2 status reset", d, 32'h0);
        rd(A_MSK, d); chk("R2 mask reset", d, 32'h0);
        rd(A_SEV, d); chk("R2 sev reset", d, SEV_INIT);
        rd(12'h100, d); chk("R1 unmapped read", d, 32'h0);
        chk("R10 outputs idle", {30'h0, fatal_o, nonfatal_o}, 32'h0);
        // R1 unmapped writes do nothing
        wr(12'h100, 32'hFFFF_FFFF); wr(12'h110, 32'hFFFF_FFFF); wr(12'h105, 32'hFFFF_FFFF);
        rd(A_MSK, d); chk("R1 mask after unmapped wr", d, 32'h0);
        rd(A_SEV, d); chk("R1 sev after unmapped wr", d, SEV_INIT);
        rd(A_STS, d); chk("R1 status after unmapped wr", d, 32'h0);
        // R6 R9 R8 all-ones writes
        wr(A_STS, 32'hFFFF_FFFF); rd(A_STS, d); chk("R6 R8 status all-ones", d, 32'h1);
        wr(A_MSK, 32'hFFFF_FFFF); rd(A_MSK, d); chk("R6 R9 R7 mask all-ones", d, CTRL_BITS);
        wr(A_SEV, 32'hFFFF_FFFF); rd(A_SEV, d); chk("R6 R9 R7 sev all-ones", d, CTRL_BITS);
        wr(A_STS, 32'h0); rd(A_STS, d); chk("R8 status bit0 cleared", d, 32'h0);
        wr(A_MSK, 32'h0); wr(A_SEV, SEV_INIT);
        // R3 R7 R8 R4 R10: single event walked across every position
        for (int k = 0; k < 32; k++) begin
            logic [31:0] b, e;
            b = 32'h1 << k;
            e = b & CLR_BITS;
            pulse(b);
            chk($sformatf("R10 fatal bit%0d", k), {31'h0, fatal_o}, {31'h0, |(e & SEV_INIT)});
            chk($sformatf("R10 nonfatal bit%0d", k), {31'h0, nonfatal_o}, {31'h0, |(e & ~SEV_INIT)});
            rd(A_STS, d); chk($sformatf("R3 R7 R8 event bit%0d", k), d, e);
            wr(A_STS, 32'h0); rd(A_STS, d); chk($sformatf("R4 zero write bit%0d", k), d, e);
            wr(A_STS, b & ~32'h1); rd(A_STS, d); chk($sformatf("R4 clear bit%0d", k), d, 32'h0);
        end
        // R5 set beats same-cycle clear
        for (int k = 0; k < 32; k++) begin
            logic [31:0] b;
            b = 32'h1 << k;
            if ((b & CLR_BITS) != 0) begin
                @(negedge clk); err_evt = b; reg_addr = A_STS; reg_wdata = b; reg_wr = 1'b1;
                @(negedge clk); err_evt = '0; reg_wr = 1'b0;
                rd(A_STS, d); chk($sformatf("R5 set wins bit%0d", k), d, b);
                wr(A_STS, b);
            end
        end
        // R10 every mask/severity pairing per clearable bit
        wr(A_SEV, 32'h0);
        for (int k = 0; k < 32; k++) begin
            logic [31:0] b;
            b = 32'h1 << k;
            if ((b & CLR_BITS) != 0) begin
                for (int c = 0; c < 4; c++) begin
                    bit m, s;
                    m = c[0]; s = c[1];
                    wr(A_MSK, m ? b : 32'h0);
                    wr(A_SEV, s ? b : 32'h0);
                    pulse(b);
                    chk($sformatf("R10 bit%0d m%0d s%0d", k, m, s),
                        {30'h0, fatal_o, nonfatal_o},
                        {30'h0, (!m && s), (!m && !s)});
                    wr(A_STS, b);
                end
            end
        end
        // R11 read sees pre-write value and holds
        wr(A_MSK, 32'h10);
        @(negedge clk); reg_addr = A_MSK; reg_wdata = 32'h20; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
        chk("R11 read before write", reg_rdata, 32'h10);
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", reg_rdata, 32'h10);
        rd(A_MSK, d); chk("R11 later read", d, 32'h20);
        done = 1;
        report();
    end
endmodule